// File: doc/BRIEF.md
# Memory Read-Modify-Write Sequencer

This block carries out one in-place arithmetic or logic update of a memory location per command. A command gives a base address, a 6-bit unsigned offset, an access size (byte, halfword or word), an operation and its operand. The operand is either a register value or a 5-bit unsigned immediate. The sequencer forms the effective address and reads the location through a simple synchronous memory port. It then combines the loaded value with the operand, writes the result back to the same address with the same size, and pulses a completion flag.

The loaded byte or halfword is sign-extended to 32 bits before the operation. Only the bytes that belong to the access size are written back. Arithmetic wraps modulo 2^32 and produces no flags. The memory port has a one-cycle read latency and addresses bytes. Data travels on the byte lanes selected by the low address bits, and byte enables mark the lanes in use. The block accepts one command at a time. Address generation beyond the base-plus-offset sum, and any sharing of the memory between masters, belong to the surrounding logic.

Top module: `mem_rmw_unit`

## Requirements
- R1: After reset, busy, done and memReq are all low.
- R2: A command accepted in the idle state produces, on consecutive cycles, the following. First a read cycle (memReq=1, memWe=0). Then one cycle with memReq=0. Then a write cycle (memReq=1, memWe=1) with the same address and byte enables as the read. Then one cycle with done=1. busy is high from the read cycle through the done cycle and low in the cycle after.
- R3: The effective address is the base plus the offset shifted left by the size scale. Size code 0 (byte) shifts by 0, code 1 (half) by 1, code 2 (word) by 2. Code 3 behaves exactly as word.
- R4: Byte enables are 4'b0001 shifted by address bits [1:0] for a byte, 4'b0011 shifted by 2*address[1] for a half, and 4'b1111 for a word. Lane k carries bits [8k+7:8k] of memRdata and memWdata.
- R5: On a write, every memWdata bit outside the enabled lanes is zero. The enabled lanes hold the low bytes of the result, truncated to the access size.
- R6: Operation codes 0, 1, 2 and 3 update the location to loaded+reg, loaded-reg, loaded AND reg and loaded OR reg, modulo 2^32.
- R7: Operation codes 4 and 5 update the location to loaded+imm and loaded-imm, with the 5-bit immediate zero-extended.
- R8: Operation code 6 clears bit imm and code 7 sets bit imm of the loaded value. A bit index beyond the access width leaves the stored bytes unchanged.
- R9: cmdValid is ignored whenever busy is high, including in the done cycle. No second memory access starts, and the running command's address and result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present; taken only when idle |
| cmdBase | input | ADDR_W | Base byte address |
| cmdOffset | input | OFF_W | Unsigned offset, scaled by size |
| cmdSize | input | 2 | 0 byte, 1 half, 2 word, 3 word |
| cmdOp | input | 3 | Operation code (see R6 to R8) |
| cmdReg | input | 32 | Register operand |
| cmdImm | input | IMM_W | Immediate operand or bit index |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Byte address of the access |
| memBe | output | 4 | Byte lane enables |
| memWdata | output | 32 | Write data, lane aligned |
| memRdata | input | 32 | Read data, valid the cycle after a read |

## Verification
A wrong controller state shows within one cycle at the memory port. The symptoms are a write with no preceding gap cycle, a second read, or done arriving without a write before it. A wrong captured address or size shows on the read cycle of the same command as a bad address or enable pattern. A wrong result shows two cycles later as wrong lane data in the memory word. Commands presented while busy are the main hazard to hidden state: overwritten command registers appear as a changed address or result in the running command's write.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LSEL_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    OP_ADD_R = 3'd0,
    OP_SUB_R = 3'd1,
    OP_AND_R = 3'd2,
    OP_OR_R  = 3'd3,
    OP_ADD_I = 3'd4,
    OP_SUB_I = 3'd5,
    OP_CLR_B = 3'd6,
    OP_SET_B = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeCmd;   // latch command fields
    logic takeData;  // capture read data and register the result
  } strobe_t;
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int IMM_W = 5
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] loaded,
  input  logic [DATA_W-1:0] regVal,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] immVal;
  logic [DATA_W-1:0] bitSel;

  assign immVal = DATA_W'(imm);
  assign bitSel = DATA_W'(1) << imm;

  always_comb begin
    unique case (op)
      OP_ADD_R: result = loaded + regVal;
      OP_SUB_R: result = loaded - regVal;
      OP_AND_R: result = loaded & regVal;
      OP_OR_R:  result = loaded | regVal;
      OP_ADD_I: result = loaded + immVal;
      OP_SUB_I: result = loaded - immVal;
      OP_CLR_B: result = loaded & ~bitSel;
      OP_SET_B: result = loaded | bitSel;
      default:  result = loaded;
    endcase
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  output strobe_t stb,
  output logic    busy,
  output logic    done,
  output logic    memReq,
  output logic    memWe
);
  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (cmdValid) stateD = ST_READ;
      ST_READ:   stateD = ST_MODIFY;
      ST_MODIFY: stateD = ST_WRITE;
      ST_WRITE:  stateD = ST_DONE;
      ST_DONE:   stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign stb.takeCmd  = (stateQ == ST_IDLE) && cmdValid;
  assign stb.takeData = (stateQ == ST_MODIFY);
  assign busy   = (stateQ != ST_IDLE);
  assign done   = (stateQ == ST_DONE);
  assign memReq = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign memWe  = (stateQ == ST_WRITE);
endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [OFF_W-1:0]  cmdOffset,
  input  logic [1:0]        cmdSize,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdReg,
  input  logic [IMM_W-1:0]  cmdImm,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata
);
  localparam int CNT_W = LSEL_W + 1;

  logic [ADDR_W-1:0] addrQ;
  size_e             sizeQ;
  op_e               opQ;
  logic [DATA_W-1:0] regQ;
  logic [IMM_W-1:0]  immQ;
  logic [DATA_W-1:0] resultQ;

  size_e             cmdSizeN;
  logic [1:0]        scale;
  logic [ADDR_W-1:0] effAddr;

  // size code 3 is folded into word at capture
  assign cmdSizeN = (size_e'(cmdSize) == SZ_WIDE) ? SZ_WORD : size_e'(cmdSize);
  assign scale    = cmdSizeN;
  assign effAddr  = cmdBase + (ADDR_W'(cmdOffset) << scale);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      sizeQ <= SZ_BYTE;
      opQ   <= OP_ADD_R;
      regQ  <= '0;
      immQ  <= '0;
    end else if (stb.takeCmd) begin
      addrQ <= effAddr;
      sizeQ <= cmdSizeN;
      opQ   <= op_e'(cmdOp);
      regQ  <= cmdReg;
      immQ  <= cmdImm;
    end
  end

  // lane placement from size and low address bits
  logic [LSEL_W-1:0] laneSel;
  logic [CNT_W-1:0]  laneCnt;

  always_comb begin
    unique case (sizeQ)
      SZ_BYTE: begin
        laneSel = addrQ[LSEL_W-1:0];
        laneCnt = CNT_W'(1);
      end
      SZ_HALF: begin
        laneSel = {addrQ[LSEL_W-1:1], 1'b0};
        laneCnt = CNT_W'(2);
      end
      default: begin
        laneSel = '0;
        laneCnt = CNT_W'(LANES);
      end
    endcase
  end

  logic [DATA_W-1:0] sizeMask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign memBe[i] = (CNT_W'(i) >= {1'b0, laneSel}) &&
                      (CNT_W'(i) <  ({1'b0, laneSel} + laneCnt));
    assign sizeMask[8*i +: 8] = {8{CNT_W'(i) < laneCnt}};
  end

  // extract and sign-extend the loaded value
  logic [DATA_W-1:0] laneData;
  logic [DATA_W-1:0] loaded;
  logic [DATA_W-1:0] aluOut;

  assign laneData = memRdata >> {laneSel, 3'b000};

  always_comb begin
    unique case (sizeQ)
      SZ_BYTE: loaded = {{(DATA_W-8){laneData[7]}}, laneData[7:0]};
      SZ_HALF: loaded = {{(DATA_W-16){laneData[15]}}, laneData[15:0]};
      default: loaded = laneData;
    endcase
  end

  rmw_alu #(.IMM_W(IMM_W)) u_alu (
    .op    (opQ),
    .loaded(loaded),
    .regVal(regQ),
    .imm   (immQ),
    .result(aluOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             resultQ <= '0;
    else if (stb.takeData) resultQ <= aluOut & sizeMask;
  end

  assign memAddr  = addrQ;
  assign memWdata = resultQ << {laneSel, 3'b000};
endmodule

// File: rtl/mem_rmw_unit.sv
module mem_rmw_unit #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [OFF_W-1:0]  cmdOffset,
  input  logic [1:0]        cmdSize,
  input  logic [2:0]        cmdOp,
  input  logic [31:0]       cmdReg,
  input  logic [IMM_W-1:0]  cmdImm,
  output logic              busy,
  output logic              done,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);
  rmw_pkg::strobe_t stb;

  rmw_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .memReq  (memReq),
    .memWe   (memWe)
  );

  rmw_datapath #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .IMM_W (IMM_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdBase  (cmdBase),
    .cmdOffset(cmdOffset),
    .cmdSize  (cmdSize),
    .cmdOp    (cmdOp),
    .cmdReg   (cmdReg),
    .cmdImm   (cmdImm),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memBe    (memBe),
    .memWdata (memWdata)
  );
endmodule

// File: rtl/mem_rmw_unit_chk.sv
module mem_rmw_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memBe,
  input logic [31:0]       memWdata
);
  logic [31:0] beMask;
  always_comb begin
    for (int i = 0; i < 4; i++) beMask[8*i +: 8] = {8{memBe[i]}};
  end

  // R2: a read is followed by one quiet cycle while still busy
  p_read_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> (!memReq && busy));

  // R2: a write is followed by the done cycle
  p_write_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> (done && !memReq));

  // R2: write reuses the read address and enables
  p_same_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr == $past(memAddr, 2) && memBe == $past(memBe, 2)));

  // R2: busy drops right after done
  p_done_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));

  // R4: enables form a legal contiguous lane group
  p_be_shape_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBe == 4'b0001 || memBe == 4'b0010 || memBe == 4'b0100 ||
                memBe == 4'b1000 || memBe == 4'b0011 || memBe == 4'b1100 ||
                memBe == 4'b1111));

  // R5: no data outside the enabled lanes
  p_lane_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> ((memWdata & ~beMask) == 32'd0));

  // R9: every busy period starts with a read
  p_start_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (memReq && !memWe));
endmodule

bind mem_rmw_unit mem_rmw_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAddr (memAddr),
  .memBe   (memBe),
  .memWdata(memWdata)
);

// File: tb/mem_rmw_unit_bench.sv
module mem_rmw_unit_bench;
  localparam int PERIOD = 10;
  localparam int NVEC   = 12;

  typedef struct packed {
    logic [31:0] base;
    logic [5:0]  off;
    logic [1:0]  size;
    logic [2:0]  op;
    logic [31:0] rv;
    logic [4:0]  imm;
    logic [31:0] pre;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] post;
  } vec_t;

  // base, off, size, op, reg, imm, word before, address, enables, word after
  localparam vec_t VEC [NVEC] = '{
    '{32'h10, 6'd1, 2'd2, 3'd0, 32'hFFFF_FFFF, 5'd0,  32'h0000_0005, 32'h14, 4'hF, 32'h0000_0004},
    '{32'h20, 6'd3, 2'd0, 3'd4, 32'h0,         5'd1,  32'h7F00_0000, 32'h23, 4'h8, 32'h8000_0000},
    '{32'h30, 6'd1, 2'd1, 3'd1, 32'h1,         5'd0,  32'h0000_1234, 32'h32, 4'hC, 32'hFFFF_1234},
    '{32'h04, 6'd0, 2'd2, 3'd2, 32'h0FF0_FF00, 5'd0,  32'hF0F0_F0F0, 32'h04, 4'hF, 32'h00F0_F000},
    '{32'h08, 6'd1, 2'd0, 3'd3, 32'hFFFF_FF0C, 5'd0,  32'h1122_3344, 32'h09, 4'h2, 32'h1122_3F44},
    '{32'h18, 6'd2, 2'd1, 3'd5, 32'h0,         5'd5,  32'hABCD_0003, 32'h1C, 4'h3, 32'hABCD_FFFE},
    '{32'h3C, 6'd0, 2'd2, 3'd6, 32'h0,         5'd31, 32'hFFFF_FFFF, 32'h3C, 4'hF, 32'h7FFF_FFFF},
    '{32'h01, 6'd1, 2'd0, 3'd7, 32'h0,         5'd7,  32'h0000_0000, 32'h02, 4'h4, 32'h0080_0000},
    '{32'h24, 6'd0, 2'd0, 3'd7, 32'h0,         5'd9,  32'h5555_5555, 32'h24, 4'h1, 32'h5555_5555},
    '{32'h00, 6'd2, 2'd3, 3'd4, 32'h0,         5'd31, 32'h0000_0010, 32'h08, 4'hF, 32'h0000_002F},
    '{32'h28, 6'd0, 2'd2, 3'd0, 32'h2,         5'd0,  32'hFFFF_FFFF, 32'h28, 4'hF, 32'h0000_0001},
    '{32'h2E, 6'd0, 2'd1, 3'd6, 32'h0,         5'd15, 32'h8001_AAAA, 32'h2E, 4'hC, 32'h0001_AAAA}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdBase = '0;
  logic [5:0]  cmdOffset = '0;
  logic [1:0]  cmdSize = '0;
  logic [2:0]  cmdOp = '0;
  logic [31:0] cmdReg = '0;
  logic [4:0]  cmdImm = '0;
  logic        busy, done, memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [3:0]  memBe;
  logic [31:0] memRdata = '0;

  logic        preEn = 1'b0;
  logic [3:0]  preIdx = '0;
  logic [31:0] preVal = '0;
  logic [31:0] mem [16];

  int checks = 0;
  int fails  = 0;
  bit over   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mem_rmw_unit u_mem_rmw_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBase(cmdBase),
    .cmdOffset(cmdOffset), .cmdSize(cmdSize), .cmdOp(cmdOp), .cmdReg(cmdReg),
    .cmdImm(cmdImm), .busy(busy), .done(done), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata)
  );

  // memory model: one-cycle read latency, byte-enabled writes, bench preload
  always @(posedge clk) begin
    if (preEn) mem[preIdx] <= preVal;
    else if (memReq && memWe) begin
      for (int i = 0; i < 4; i++)
        if (memBe[i]) mem[memAddr[5:2]][8*i +: 8] <= memWdata[8*i +: 8];
    end
    if (memReq && !memWe) memRdata <= mem[memAddr[5:2]];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    preEn = 1'b1; preIdx = idx; preVal = val;
    @(negedge clk);
    preEn = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    cmdValid = 1'b1; cmdBase = v.base; cmdOffset = v.off; cmdSize = v.size;
    cmdOp = v.op; cmdReg = v.rv; cmdImm = v.imm;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] rdA, wrA, wrD;
    logic [3:0]  rdB, wrB;
    logic [4:0]  seq [5];
    logic [31:0] mask;
    string tag;
    preload(v.addr[5:2], v.pre);
    drive(v);                      // at a negedge, taken at the next posedge
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (c == 0) cmdValid = 1'b0;
      seq[c] = {memReq, memWe, done, busy, 1'b0};
      if (c == 0) begin rdA = memAddr; rdB = memBe; end
      if (c == 2) begin wrA = memAddr; wrB = memBe; wrD = memWdata; end
    end
    check(seq[0] == 5'b10010 && seq[1] == 5'b00010 && seq[2] == 5'b11010 &&
          seq[3] == 5'b00110 && seq[4] == 5'b00000, "R2 sequence",
          {7'd0, seq[0], seq[1], seq[2], seq[3], seq[4]},
          {7'd0, 5'b10010, 5'b00010, 5'b11010, 5'b00110, 5'b00000});
    check(rdA == v.addr, "R3 address", rdA, v.addr);
    check(rdB == v.be, "R4 enables", {28'd0, rdB}, {28'd0, v.be});
    check(wrA == rdA && wrB == rdB, "R2 write target", wrA, rdA);
    for (int i = 0; i < 4; i++) mask[8*i +: 8] = {8{v.be[i]}};
    check((wrD & ~mask) == 32'd0, "R5 lanes", wrD, wrD & mask);
    if (v.op < 3'd4)      tag = "R6 result";
    else if (v.op < 3'd6) tag = "R7 result";
    else                  tag = "R8 result";
    check(mem[v.addr[5:2]] == v.post, tag, mem[v.addr[5:2]], v.post);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!over) begin
      over = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int reqCount;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !memReq, "R1 reset outputs",
          {29'd0, busy, done, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq, "R1 idle after release", {30'd0, busy, memReq}, 32'd0);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R9: second command held through the whole busy period is ignored
    preload(4'd4, 32'h0000_0100);
    preload(4'd8, 32'h0000_0000);
    drive('{32'h10, 6'd0, 2'd2, 3'd4, 32'h0, 5'd3, 32'h0, 32'h10, 4'hF, 32'h0});
    @(negedge clk);
    // switch to another target while busy, hold until the done cycle
    cmdBase = 32'h20; cmdOp = 3'd7; cmdImm = 5'd0; cmdSize = 2'd2;
    @(negedge clk);
    @(negedge clk);
    check(memAddr == 32'h10 && memWe, "R9 running address", memAddr, 32'h10);
    @(negedge clk);
    check(done, "R9 done on time", {31'd0, done}, 32'd1);
    @(negedge clk);
    cmdValid = 1'b0;
    reqCount = 0;
    for (int c = 0; c < 4; c++) begin
      if (memReq || busy) reqCount++;
      @(negedge clk);
    end
    check(reqCount == 0, "R9 no extra access", reqCount, 32'd0);
    check(mem[4] == 32'h0000_0103, "R9 running result", mem[4], 32'h0000_0103);
    check(mem[8] == 32'h0000_0000, "R9 other word untouched", mem[8], 32'h0);

    // R1: reset in the middle of a command returns to idle
    drive(VEC[0]);
    @(negedge clk);
    cmdValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(!busy && !done && !memReq, "R1 mid-command reset",
          {29'd0, busy, done, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    if (!over) begin
      over = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule